// File: doc/BRIEF.md
# Two-Speed Coarse/Fine Angle Generator

This block produces the angle commands for a pair of outputs that work as one two-speed channel. Software programs a single coarse angle. The first output repeats that angle. The second output carries the fine angle, which is the coarse angle multiplied by a programmable integer speed ratio and wrapped to one turn. Angles are unsigned fractions of a full turn, 16 bits wide by default.

Three registers are written through a simple write port: the coarse angle, the speed ratio and a two-bit output-mode field. The mode field is passed straight through as one flag per output. A 0 asks the downstream driver for ratio-metric operation, where the amplitude follows the reference. A 1 asks for fixed amplitude. Waveform synthesis and amplitude scaling belong to the stages downstream.

Both angle outputs come from one output register, so a downstream reader never sees a coarse angle paired with a fine angle that was computed from different settings.

Top module: `two_speed_angle_gen`

## Requirements
- R1: After reset, `coarse_o`, `fine_o` and `mode_fixed_o` are all zero and the effective ratio is 1.
- R2: A write with `wr_sel` = 0 loads `wr_data` as the coarse angle. The value appears on `coarse_o` at the second rising edge, counting the edge that accepts the write as the first.
- R3: `fine_o` equals the low 16 bits of the product of the coarse angle and the ratio, which wraps the fine angle modulo one turn.
- R4: A write with `wr_sel` = 1 takes the ratio from `wr_data[7:0]`, which covers 1 to 255. Bits 15:8 of that write have no effect.
- R5: A ratio write of 0 behaves exactly like a ratio write of 1.
- R6: With a ratio of 1, `fine_o` equals `coarse_o`.
- R7: A write to either the coarse angle or the ratio changes `coarse_o` and `fine_o` on the same edge, one edge after the write is accepted. At the accepting edge both outputs keep their previous values.
- R8: A write with `wr_sel` = 2 loads `wr_data[1:0]` into `mode_fixed_o` at the accepting edge. Bit 0 belongs to the coarse output and bit 1 to the fine output. A 0 in a bit means ratio-metric and a 1 means fixed.
- R9: A write with `wr_sel` = 3 changes nothing. With no write, all outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_sel | input | 2 | Register select: 0 coarse angle, 1 ratio, 2 mode, 3 unused |
| wr_data | input | 16 | Write data |
| coarse_o | output | 16 | Coarse angle, fraction of a turn |
| fine_o | output | 16 | Fine angle, coarse angle times ratio modulo one turn |
| mode_fixed_o | output | 2 | Per-output mode flag, 1 = fixed, 0 = ratio-metric |

## Verification
On every cycle the assertions check several things. A coarse write reaches `coarse_o` two edges later, and a mode write reaches `mode_fixed_o` at the accepting edge. The angle outputs hold steady across quiet cycles. A ratio write of 0 or 1 leaves the fine output equal to the coarse output, and an even ratio forces the low fine bit to zero. The full wrapped product for arbitrary pairs, the masking of the upper ratio bits, the ignored select code, and the rule that neither angle moves at the accepting edge are shown only by the bench. It does so with directed corner values such as the largest angle times the largest ratio, and with a long random sequence of mixed writes.

// File: rtl/tsg_pkg.sv
package tsg_pkg;
   typedef enum logic [1:0] {
      SEL_COARSE = 2'd0,
      SEL_RATIO  = 2'd1,
      SEL_MODE   = 2'd2,
      SEL_NONE   = 2'd3
   } tsg_sel_e;

   localparam int unsigned MODE_BITS = 2;
endpackage

// File: rtl/tsg_cfg_regs.sv
module tsg_cfg_regs
   import tsg_pkg::*;
#(
   parameter int unsigned ANGLE_W = 16,
   parameter int unsigned RATIO_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [1:0]           wr_sel,
   input  logic [ANGLE_W-1:0]   wr_data,
   output logic [ANGLE_W-1:0]   coarse_q,
   output logic [RATIO_W-1:0]   ratio_q,
   output logic [MODE_BITS-1:0] mode_q
);
   localparam logic [RATIO_W-1:0] RATIO_ONE = RATIO_W'(1);

   tsg_sel_e              sel;
   logic [RATIO_W-1:0]    ratio_field;
   logic [RATIO_W-1:0]    ratio_norm;

   assign sel         = tsg_sel_e'(wr_sel);
   assign ratio_field = wr_data[RATIO_W-1:0];
   assign ratio_norm  = (ratio_field == '0) ? RATIO_ONE : ratio_field;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         coarse_q <= '0;
         ratio_q  <= RATIO_ONE;
         mode_q   <= '0;
      end else if (wr_en) begin
         case (sel)
            SEL_COARSE: coarse_q <= wr_data;
            SEL_RATIO:  ratio_q  <= ratio_norm;
            SEL_MODE:   mode_q   <= wr_data[MODE_BITS-1:0];
            default:    ;
         endcase
      end
   end
endmodule

// File: rtl/tsg_ratio_mult.sv
module tsg_ratio_mult #(
   parameter int unsigned ANGLE_W   = 16,
   parameter int unsigned RATIO_W   = 8,
   parameter bit          SHIFT_ADD = 1'b0
) (
   input  logic [ANGLE_W-1:0] angle,
   input  logic [RATIO_W-1:0] ratio,
   output logic [ANGLE_W-1:0] product
);
   localparam int unsigned FULL_W = ANGLE_W + RATIO_W;

   generate
      if (SHIFT_ADD) begin : g_shift_add
         logic [ANGLE_W-1:0] partial [RATIO_W+1];
         assign partial[0] = '0;
         for (genvar i = 0; i < RATIO_W; i++) begin : g_term
            logic [ANGLE_W-1:0] shifted;
            assign shifted      = angle << i;
            assign partial[i+1] = partial[i] + (ratio[i] ? shifted : '0);
         end
         assign product = partial[RATIO_W];
      end else begin : g_native
         logic [FULL_W-1:0] full;
         assign full    = FULL_W'(angle) * FULL_W'(ratio);
         assign product = full[ANGLE_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/tsg_out_stage.sv
module tsg_out_stage #(
   parameter int unsigned ANGLE_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ANGLE_W-1:0] coarse_in,
   input  logic [ANGLE_W-1:0] fine_in,
   output logic [ANGLE_W-1:0] coarse_out,
   output logic [ANGLE_W-1:0] fine_out
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         coarse_out <= '0;
         fine_out   <= '0;
      end else begin
         coarse_out <= coarse_in;
         fine_out   <= fine_in;
      end
   end
endmodule

// File: rtl/two_speed_angle_gen.sv
module two_speed_angle_gen
   import tsg_pkg::*;
#(
   parameter int unsigned ANGLE_W   = 16,
   parameter int unsigned RATIO_W   = 8,
   parameter bit          SHIFT_ADD = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [1:0]           wr_sel,
   input  logic [ANGLE_W-1:0]   wr_data,
   output logic [ANGLE_W-1:0]   coarse_o,
   output logic [ANGLE_W-1:0]   fine_o,
   output logic [MODE_BITS-1:0] mode_fixed_o
);
   generate
      if (RATIO_W < 1 || RATIO_W > ANGLE_W) begin : g_bad_ratio_w
         $error("two_speed_angle_gen: RATIO_W must be between 1 and ANGLE_W");
      end
      if (ANGLE_W < MODE_BITS) begin : g_bad_angle_w
         $error("two_speed_angle_gen: ANGLE_W too narrow for the mode field");
      end
   endgenerate

   logic [ANGLE_W-1:0] coarse_q;
   logic [RATIO_W-1:0] ratio_q;
   logic [ANGLE_W-1:0] fine_d;

   tsg_cfg_regs #(.ANGLE_W(ANGLE_W), .RATIO_W(RATIO_W)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_sel   (wr_sel),
      .wr_data  (wr_data),
      .coarse_q (coarse_q),
      .ratio_q  (ratio_q),
      .mode_q   (mode_fixed_o)
   );

   tsg_ratio_mult #(.ANGLE_W(ANGLE_W), .RATIO_W(RATIO_W), .SHIFT_ADD(SHIFT_ADD)) u_mult (
      .angle   (coarse_q),
      .ratio   (ratio_q),
      .product (fine_d)
   );

   tsg_out_stage #(.ANGLE_W(ANGLE_W)) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .coarse_in  (coarse_q),
      .fine_in    (fine_d),
      .coarse_out (coarse_o),
      .fine_out   (fine_o)
   );
endmodule

// File: rtl/tsg_chk.sv
module tsg_chk #(
   parameter int unsigned ANGLE_W = 16,
   parameter int unsigned RATIO_W = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic [1:0]         wr_sel,
   input logic [ANGLE_W-1:0] wr_data,
   input logic [ANGLE_W-1:0] coarse_o,
   input logic [ANGLE_W-1:0] fine_o,
   input logic [1:0]         mode_fixed_o
);
   logic [1:0] warm;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         warm <= '0;
      else if (warm != 2'd3) warm <= warm + 2'd1;
   end

   // R2
   coarse_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd0) |=> ##1 (coarse_o == $past(wr_data, 2)));

   // R8
   mode_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd2) |=> (mode_fixed_o == $past(wr_data[1:0])));

   // R9
   quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm >= 2'd2 && !wr_en && !$past(wr_en)) |=> ($stable(coarse_o) && $stable(fine_o)));

   // R5
   unity_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd1 && wr_data[RATIO_W-1:0] <= RATIO_W'(1)) |=> ##1 (fine_o == coarse_o));

   // R3
   even_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd1 && wr_data[0] == 1'b0 && wr_data[RATIO_W-1:0] != '0) |=> ##1 (fine_o[0] == 1'b0));
endmodule

bind two_speed_angle_gen tsg_chk #(.ANGLE_W(ANGLE_W), .RATIO_W(RATIO_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_en        (wr_en),
   .wr_sel       (wr_sel),
   .wr_data      (wr_data),
   .coarse_o     (coarse_o),
   .fine_o       (fine_o),
   .mode_fixed_o (mode_fixed_o)
);

// File: tb/two_speed_angle_gen_test.sv
module two_speed_angle_gen_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'd0;
   logic [15:0] wr_data = 16'd0;
   logic [15:0] coarse_o, fine_o;
   logic [1:0]  mode_fixed_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [15:0] m_coarse = 16'd0;
   logic [7:0]  m_ratio  = 8'd1;
   logic [1:0]  m_mode   = 2'd0;

   two_speed_angle_gen uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .coarse_o(coarse_o), .fine_o(fine_o), .mode_fixed_o(mode_fixed_o)
   );

   always #5 clk = ~clk;

   function automatic logic [15:0] exp_fine(input logic [15:0] c, input logic [7:0] r);
      logic [31:0] p;
      p = 32'(c) * 32'(r);
      return p[15:0];
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, expv);
      end
   endtask

   task automatic check_all(input string req);
      check({req, " coarse"}, coarse_o, m_coarse);
      check({req, " fine"}, fine_o, exp_fine(m_coarse, m_ratio));
      check({req, " mode"}, 16'(mode_fixed_o), 16'(m_mode));
   endtask

   // Drive at negedge; after the accepting edge the angles must be unchanged (R7),
   // mode must already be updated (R8); one edge later angles reflect the write.
   task automatic do_write(input logic [1:0] sel, input logic [15:0] data, input string req);
      logic [15:0] old_c, old_f;
      old_c = m_coarse;
      old_f = exp_fine(m_coarse, m_ratio);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
      case (sel)
         2'd0: m_coarse = data;
         2'd1: m_ratio  = (data[7:0] == 8'd0) ? 8'd1 : data[7:0];
         2'd2: m_mode   = data[1:0];
         default: ;
      endcase
      check("R7 coarse held at accept", coarse_o, old_c);
      check("R7 fine held at accept", fine_o, old_f);
      check("R8 mode at accept", 16'(mode_fixed_o), 16'(m_mode));
      @(negedge clk);
      check_all(req);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 coarse", coarse_o, 16'd0);
      check("R1 fine", fine_o, 16'd0);
      check("R1 mode", 16'(mode_fixed_o), 16'd0);
      // R1 default ratio is 1, R6
      do_write(2'd0, 16'h1234, "R1 default ratio");
      check("R6 unity", fine_o, coarse_o);
      // R2, R3
      do_write(2'd1, 16'd36, "R3 ratio 36");
      do_write(2'd0, 16'h0E39, "R2 coarse write");
      // R3 wrap at extremes
      do_write(2'd1, 16'd255, "R3 ratio 255");
      do_write(2'd0, 16'hFFFF, "R3 wrap max");
      check("R3 max product", fine_o, 16'hFF01);
      // R5 zero ratio
      do_write(2'd1, 16'd0, "R5 zero ratio");
      check("R5 fine equals coarse", fine_o, 16'hFFFF);
      // R4 upper bits ignored
      do_write(2'd1, 16'hAB05, "R4 upper bits");
      check("R4 ratio 5", fine_o, exp_fine(16'hFFFF, 8'd5));
      // R8 modes
      do_write(2'd2, 16'hFFFE, "R8 mode ch2 fixed");
      do_write(2'd2, 16'h0001, "R8 mode ch1 fixed");
      // R9 unused select and idle hold
      do_write(2'd3, 16'h5A5A, "R9 unused select");
      repeat (5) @(negedge clk);
      check_all("R9 idle hold");
      // random mix
      for (int i = 0; i < 400; i++) begin
         logic [1:0]  s;
         logic [15:0] d;
         s = 2'($urandom % 4);
         d = 16'($urandom);
         do_write(s, d, "R3 random");
      end
      done = 1'b1;
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected done");
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule